// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execution datapath of a small processor core. It takes two operands and a four-bit operation code, and it produces a result on the same cycle. A result-valid strobe tells the register file whether that result should be written to a destination. The block also holds a four-bit status register with negative, zero, carry and overflow flags. This register is loaded on the clock edge.

The carry flag held in the status register feeds the with-carry add and subtract operations. Logical operations take their carry flag from a separate carry bit that the operand shifter supplies. The compare and test operations update only the status register and produce no destination write. Other operations update the flags only when the set-flags control is high. Multiply, the operand shifter, condition evaluation and the register file are outside this block.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `status` is loaded with 4'b0000. It is observed as 0 from the next cycle.
- R2: The add codes form `a + b` (code 4) and `a + b + C` (code 5), where C is `status[1]`. A set-flags update loads C with the carry out of bit 31. It loads V with signed overflow.
- R3: The subtract codes form `a - b` (code 2), `b - a` (code 3, reverse) and `a - b - (1 - C)` (code 6). A set-flags update loads C with 1 when no borrow occurs and 0 when a borrow occurs. It loads V with signed overflow of the difference.
- R4: On every flag update, `status[3]` (N) takes bit 31 of the operation's value. `status[2]` (Z) takes 1 exactly when that value is zero.
- R5: The logical codes give `a & b` (0), `a ^ b` (1), `a | b` (7), `a & ~b` (12, bit clear), `b` (13, move) and `~b` (14, complement move). A flag update from any of these loads C (`status[1]`) from `shift_carry`. It keeps V (`status[0]`) unchanged.
- R6: The compare codes are 8 (AND test), 9 (XOR test), 10 (subtract compare) and 11 (add compare). They update N, Z, C and V as their logical or arithmetic counterparts would, whatever the value of `set_flags`. They always hold `result_valid` low.
- R7: For codes 0 to 7 and 12 to 14, `result_valid` is high. With `set_flags` low, `status` keeps its value across the clock edge.
- R8: Code 15 is reserved. It drives `result` to 0 and `result_valid` low, and it leaves `status` unchanged even with `set_flags` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the status register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (shifter output) |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request a status update for non-compare operations |
| shift_carry | input | 1 | Carry out of the operand shifter, used by logical flag updates |
| result | output | 32 | Combinational operation result |
| result_valid | output | 1 | High when the result is to be written to a destination |
| status | output | 4 | Registered flags {N, Z, C, V} |

## Verification
The bench targets the following corner cases:

- **Borrow polarity.** The bench covers subtractions that do and do not borrow, and equal operands. A design that used a raw borrow instead of its inverse would show the opposite C flag after a compare of equal values.
- **Carry chaining.** The bench chains a with-carry add or subtract after a flag-setting operation, with the held carry at both 0 and 1. A design that ignored the held carry would be off by one.
- **Signed overflow.** Operands near 0x7FFFFFFF and 0x80000000 exercise the overflow rule, including reverse subtract. Reverse subtract is where a design that tested the signs of the wrong operand would mark V wrongly.
- **Flag-only and reserved codes.** Logical updates are run with V previously set, and compares are run with `set_flags` low. Reserved codes are run with `set_flags` high. These catch a design that clears V, skips a compare update or writes flags on a reserved code.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_XOR = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_ORR = 4'd7,
        OP_TST = 4'd8,
        OP_TEQ = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_BIC = 4'd12,
        OP_MOV = 4'd13,
        OP_MVN = 4'd14,
        OP_RSV = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_compare(alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_SUB) || (op == OP_RSB) || (op == OP_ADD) || (op == OP_ADC) ||
               (op == OP_SBC) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_reserved(alu_op_e op);
        return op == OP_RSV;
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder
    import flag_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   sum,
    output logic               carry_out,
    output logic               overflow
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] lhs;
    logic [WIDTH-1:0] rhs;
    logic             cin;
    logic [WIDTH:0]   wide;

    always_comb begin
        lhs = a;
        rhs = b;
        cin = 1'b0;
        unique case (op)
            OP_ADD, OP_CMN: cin = 1'b0;
            OP_ADC:         cin = carry_in;
            OP_SUB, OP_CMP: begin rhs = ~b; cin = 1'b1; end
            OP_SBC:         begin rhs = ~b; cin = carry_in; end
            OP_RSB:         begin lhs = b; rhs = ~a; cin = 1'b1; end
            default:        cin = 1'b0;
        endcase
        wide      = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin};
        sum       = wide[WIDTH-1:0];
        carry_out = wide[WIDTH];
        overflow  = (lhs[MSB] == rhs[MSB]) && (wide[MSB] != lhs[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import flag_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: y = a & b;
            OP_XOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_BIC:         y = a & ~b;
            OP_MOV:         y = b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import flag_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  nzcv_t next_flags,
    output nzcv_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (load) begin
            flags <= next_flags;
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       opcode,
    input  logic             set_flags,
    input  logic             shift_carry,
    output logic [WIDTH-1:0] result,
    output logic             result_valid,
    output logic [3:0]       status
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_op_e          op;
    nzcv_t            cur_flags;
    nzcv_t            nxt_flags;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] value;
    logic             arith_c;
    logic             arith_v;
    logic             is_arith;
    logic             is_cmp;
    logic             is_rsv;
    logic             flag_load;

    assign op       = alu_op_e'(opcode);
    assign is_arith = op_is_arith(op);
    assign is_cmp   = op_is_compare(op);
    assign is_rsv   = op_is_reserved(op);

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .op        (op),
        .a         (op_a),
        .b         (op_b),
        .carry_in  (cur_flags.c),
        .sum       (arith_y),
        .carry_out (arith_c),
        .overflow  (arith_v)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op (op),
        .a  (op_a),
        .b  (op_b),
        .y  (logic_y)
    );

    always_comb begin
        value       = is_arith ? arith_y : logic_y;
        nxt_flags.n = value[MSB];
        nxt_flags.z = (value == '0);
        nxt_flags.c = is_arith ? arith_c : shift_carry;
        nxt_flags.v = is_arith ? arith_v : cur_flags.v;
        flag_load   = !is_rsv && (set_flags || is_cmp);
    end

    assign result       = is_rsv ? '0 : value;
    assign result_valid = !is_rsv && !is_cmp;
    assign status       = cur_flags;

    alu_status_reg u_status (
        .clk        (clk),
        .rst        (rst),
        .load       (flag_load),
        .next_flags (nxt_flags),
        .flags      (cur_flags)
    );
endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       opcode,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             result_valid,
    input logic [3:0]       status
);
    logic cmp_code;
    logic logic_code;
    assign cmp_code   = (opcode >= 4'd8) && (opcode <= 4'd11);
    assign logic_code = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd7) ||
                        (opcode >= 4'd12 && opcode <= 4'd14);

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> status == 4'b0000);

    a_r6_compare_no_write: assert property (@(posedge clk) disable iff (rst)
        cmp_code |-> !result_valid);

    a_r7_hold_without_request: assert property (@(posedge clk) disable iff (rst)
        (!set_flags && !cmp_code) |=> $stable(status));

    a_r5_logic_keeps_v: assert property (@(posedge clk) disable iff (rst)
        logic_code |=> status[0] == $past(status[0]));

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (set_flags && result_valid) |=> status[2] == ($past(result) == '0));

    a_r8_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd15) |-> (!result_valid && result == '0));
endmodule

bind flag_alu flag_alu_checker #(.WIDTH(WIDTH)) u_flag_alu_checker (
    .clk          (clk),
    .rst          (rst),
    .opcode       (opcode),
    .set_flags    (set_flags),
    .result       (result),
    .result_valid (result_valid),
    .status       (status)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  opcode = 4'd13;
    logic        set_flags = 1'b0;
    logic        shift_carry = 1'b0;
    logic [31:0] result;
    logic        result_valid;
    logic [3:0]  status;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] m_st = 4'b0000;

    always #10 clk = ~clk;

    flag_alu i_flag_alu (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .set_flags(set_flags), .shift_carry(shift_carry),
        .result(result), .result_valid(result_valid), .status(status)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd2, 4'd3, 4'd6: return "R3";
            4'd4, 4'd5:       return "R2";
            4'd8, 4'd9, 4'd10, 4'd11: return "R6";
            4'd15:            return "R8";
            default:          return "R5";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic sf, input logic sc);
        longint ua, ub, cin, wide, sa, sb, sres;
        logic [31:0] val;
        logic        is_ar, is_cmp, wr, c_new, v_new, upd;
        logic [3:0]  nst;
        @(negedge clk);
        op_a = a; op_b = b; opcode = op; set_flags = sf; shift_carry = sc;
        ua = longint'(a); ub = longint'(b); cin = longint'(m_st[1]);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        is_ar = 1'b1; c_new = 1'b0; sres = 0; val = '0;
        case (op)
            4'd4, 4'd11: begin wide = ua + ub;       sres = sa + sb;       c_new = wide > 64'hFFFF_FFFF; end
            4'd5:        begin wide = ua + ub + cin; sres = sa + sb + cin; c_new = wide > 64'hFFFF_FFFF; end
            4'd2, 4'd10: begin wide = ua - ub;       sres = sa - sb;       c_new = ua >= ub; end
            4'd3:        begin wide = ub - ua;       sres = sb - sa;       c_new = ub >= ua; end
            4'd6:        begin wide = ua - ub - (1 - cin); sres = sa - sb - (1 - cin);
                               c_new = ua >= ub + (1 - cin); end
            default:     begin is_ar = 1'b0; wide = 0; end
        endcase
        if (is_ar) val = wide[31:0];
        else case (op)
            4'd0, 4'd8:  val = a & b;
            4'd1, 4'd9:  val = a ^ b;
            4'd7:        val = a | b;
            4'd12:       val = a & ~b;
            4'd13:       val = b;
            4'd14:       val = ~b;
            default:     val = '0;
        endcase
        v_new  = is_ar ? ((sres > 64'sd2147483647) || (sres < -64'sd2147483648)) : m_st[0];
        if (!is_ar) c_new = sc;
        is_cmp = (op >= 4'd8) && (op <= 4'd11);
        wr     = (op != 4'd15) && !is_cmp;
        upd    = (op != 4'd15) && (sf || is_cmp);
        nst    = {val[31], val == 32'd0, c_new, v_new};
        #2;
        check(req_of(op), "result_valid", {31'd0, result_valid}, {31'd0, wr});
        if (wr || op == 4'd15) check(req_of(op), "result", result, val);
        @(posedge clk);
        if (upd) m_st = nst;
        #2;
        check(upd ? "R4" : (op == 4'd15 ? "R8" : "R7"), "status", {28'd0, status}, {28'd0, m_st});
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", "status after reset", {28'd0, status}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // R2 adds, carry chaining
        run_op(4'd4, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0);
        run_op(4'd5, 32'd10, 32'd20, 1'b1, 1'b0);
        run_op(4'd5, 32'd10, 32'd20, 1'b1, 1'b0);
        run_op(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0);
        // R3 subtracts, borrow polarity
        run_op(4'd2, 32'd5, 32'd5, 1'b1, 1'b0);
        run_op(4'd2, 32'd3, 32'd7, 1'b1, 1'b0);
        run_op(4'd6, 32'd100, 32'd1, 1'b1, 1'b0);
        run_op(4'd6, 32'd100, 32'd1, 1'b1, 1'b0);
        run_op(4'd3, 32'd1, 32'h8000_0000, 1'b1, 1'b0);
        run_op(4'd3, 32'd9, 32'd4, 1'b1, 1'b0);
        run_op(4'd2, 32'h8000_0000, 32'd1, 1'b1, 1'b0);
        // R5 logical keeps V, takes shifter carry
        run_op(4'd0, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1, 1'b1);
        run_op(4'd12, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b1, 1'b0);
        run_op(4'd14, 32'd0, 32'd0, 1'b1, 1'b1);
        run_op(4'd13, 32'd0, 32'd0, 1'b1, 1'b0);
        run_op(4'd7, 32'h1, 32'h8000_0000, 1'b1, 1'b1);
        run_op(4'd1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, 1'b0);
        // R7 no update without request
        run_op(4'd2, 32'd1, 32'd2, 1'b0, 1'b1);
        run_op(4'd13, 32'd0, 32'd0, 1'b0, 1'b1);
        // R6 compares update regardless of set_flags
        run_op(4'd10, 32'd5, 32'd5, 1'b0, 1'b0);
        run_op(4'd11, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0);
        run_op(4'd8, 32'hFF00, 32'h00FF, 1'b0, 1'b1);
        run_op(4'd9, 32'h1234, 32'h1235, 1'b1, 1'b0);
        // R8 reserved code
        run_op(4'd15, 32'd0, 32'd0, 1'b1, 1'b1);
        run_op(4'd15, 32'hDEAD_BEEF, 32'h1, 1'b1, 1'b0);

        for (int i = 0; i < 400; i++)
            run_op(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom), 1'($urandom));

        // R1 reset mid-run
        run_op(4'd2, 32'd0, 32'd1, 1'b1, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        check("R1", "status after second reset", {28'd0, status}, 32'd0);
        m_st = 4'b0000;
        @(negedge clk); rst = 1'b0;
        run_op(4'd5, 32'd1, 32'd1, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule